// File: doc/BRIEF.md
# DMA Event Status and Interrupt Mask Word

This block is the interrupt collection point of a ten-channel DMA engine. Each channel's logic sends a one-cycle pulse when a transfer completes. The engine's global logic sends pulses for three conditions: a bus error, a stall, and a memory-FIFO drain that has emptied. Each pulse sets a sticky status bit.

A second group of bits in the same 32-bit word enables each status bit onto a single interrupt line. The exception is bus error, which always raises the interrupt. Software reads the word through a combinational read port and changes it through a single-cycle write strobe. The write semantics differ by field. A one written to a status position clears that status bit. A one written to a mask position flips that mask bit. A zero written to any position leaves that bit unchanged, so one write can acknowledge events and adjust enables without a read-modify-write.

The register write and read paths are plain control signals with no handshake. A write is accepted on every cycle in which the strobe is high.

Top module: `dma_irq_csr`

## Requirements
- R1: A pulse on channel n's done input sets status bit n (bits 0 to 9), and the bit is visible on the read port after the next clock edge. The bit then stays set until it is cleared.
- R2: The stall pulse sets bit 13, the FIFO-empty pulse sets bit 14 and the bus-error pulse sets bit 15. Each bit is visible after the next clock edge and stays set until it is cleared.
- R3: A write with a one at a status position (0 to 9, 13, 14, 15) clears that bit. A zero at a status position leaves the bit unchanged.
- R4: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write with a one at a mask position inverts that mask bit. The mask positions are 16+n for channel n, 29 for stall and 30 for FIFO-empty. A zero at a mask position leaves the bit unchanged.
- R6: The interrupt output is registered. After each clock edge it equals the OR of the following terms, evaluated on the word as it stood before that edge: each of the channel, stall and FIFO-empty status bits ANDed with its own mask bit, and bus-error status with no mask.
- R7: Bits 10 to 12, 26 to 28 and 31 always read as zero, and writes have no effect on them.
- R8: During reset and after it, the word reads zero and the interrupt output is low until an event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; wr_data is applied at this edge |
| wr_data | input | 32 | Write value: ones clear status bits and flip mask bits |
| ch_done | input | NUM_CH | Per-channel completion pulses |
| stall_evt | input | 1 | Stall event pulse |
| fifo_empty_evt | input | 1 | Memory-FIFO-empty event pulse |
| bus_err_evt | input | 1 | Bus-error event pulse |
| rd_data | output | 32 | Current status and mask word |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default of ten channels. With that setting the channel field fills bits 0 to 9 and its masks fill bits 16 to 25, so every defined position and every hole in the word is exercised. An all-ones write therefore touches every clear, every toggle and every reserved bit in a single cycle. A random phase then mixes events, clears and toggles, so that collisions between events and clears and the one-cycle interrupt lag occur many times.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int WORD_W        = 32;
  localparam int STALL_POS     = 13;
  localparam int FIFO_POS      = 14;
  localparam int BERR_POS      = 15;
  localparam int MASK_OFS      = 16;
  localparam int STALL_MSK_POS = 29;
  localparam int FIFO_MSK_POS  = 30;
  typedef logic [WORD_W-1:0] csr_word_t;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/irq_toggle_bank.sv
module irq_toggle_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tgl_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_o ^ tgl_i;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] msk_i,
  input  logic         force_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= (|(sts_i & msk_i)) | force_i;
  end
endmodule

// File: rtl/dma_irq_csr.sv
module dma_irq_csr
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic              stall_evt,
  input  logic              fifo_empty_evt,
  input  logic              bus_err_evt,
  output logic [31:0]       rd_data,
  output logic              irq
);
  // maskable sources: channels, then stall, then fifo-empty
  localparam int NM      = NUM_CH + 2;
  localparam int IX_STL  = NUM_CH;
  localparam int IX_FIFO = NUM_CH + 1;
  localparam int IX_BERR = NM;

  logic [NM:0]   sts_set, sts_clr, sts_q;
  logic [NM-1:0] msk_tgl, msk_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign sts_set[n] = ch_done[n];
    assign sts_clr[n] = wr_en & wr_data[n];
    assign msk_tgl[n] = wr_en & wr_data[MASK_OFS+n];
  end

  assign sts_set[IX_STL]  = stall_evt;
  assign sts_set[IX_FIFO] = fifo_empty_evt;
  assign sts_set[IX_BERR] = bus_err_evt;
  assign sts_clr[IX_STL]  = wr_en & wr_data[STALL_POS];
  assign sts_clr[IX_FIFO] = wr_en & wr_data[FIFO_POS];
  assign sts_clr[IX_BERR] = wr_en & wr_data[BERR_POS];
  assign msk_tgl[IX_STL]  = wr_en & wr_data[STALL_MSK_POS];
  assign msk_tgl[IX_FIFO] = wr_en & wr_data[FIFO_MSK_POS];

  irq_sticky_bank #(.W(NM+1)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i(sts_set), .clr_i(sts_clr), .q_o(sts_q)
  );

  irq_toggle_bank #(.W(NM)) u_msk (
    .clk(clk), .rst_n(rst_n), .tgl_i(msk_tgl), .q_o(msk_q)
  );

  irq_merge #(.W(NM)) u_irq (
    .clk(clk), .rst_n(rst_n), .sts_i(sts_q[NM-1:0]), .msk_i(msk_q),
    .force_i(sts_q[IX_BERR]), .irq_o(irq)
  );

  always_comb begin
    rd_data = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      rd_data[n]          = sts_q[n];
      rd_data[MASK_OFS+n] = msk_q[n];
    end
    rd_data[STALL_POS]     = sts_q[IX_STL];
    rd_data[FIFO_POS]      = sts_q[IX_FIFO];
    rd_data[BERR_POS]      = sts_q[IX_BERR];
    rd_data[STALL_MSK_POS] = msk_q[IX_STL];
    rd_data[FIFO_MSK_POS]  = msk_q[IX_FIFO];
  end
endmodule

// File: rtl/dma_irq_csr_chk.sv
module dma_irq_csr_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [NUM_CH-1:0] ch_done,
  input logic              stall_evt,
  input logic              fifo_empty_evt,
  input logic              bus_err_evt,
  input logic [31:0]       rd_data,
  input logic              irq
);
  function automatic logic [31:0] live_bits();
    logic [31:0] m = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      m[n] = 1'b1;
      m[MASK_OFS+n] = 1'b1;
    end
    m[STALL_POS] = 1'b1; m[FIFO_POS] = 1'b1; m[BERR_POS] = 1'b1;
    m[STALL_MSK_POS] = 1'b1; m[FIFO_MSK_POS] = 1'b1;
    return m;
  endfunction
  localparam logic [31:0] LIVE = live_bits();

  function automatic logic want_irq(input logic [31:0] w);
    logic r = w[BERR_POS];
    for (int n = 0; n < NUM_CH; n++) r |= w[n] & w[MASK_OFS+n];
    r |= w[STALL_POS] & w[STALL_MSK_POS];
    r |= w[FIFO_POS] & w[FIFO_MSK_POS];
    return r;
  endfunction

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    a_r1_ch_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[n] |=> rd_data[n]);
  end

  a_r2_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> rd_data[STALL_POS]);
  a_r2_berr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_evt |=> rd_data[BERR_POS]);
  a_r3_berr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BERR_POS] && !bus_err_evt) |=> !rd_data[BERR_POS]);
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FIFO_POS] && fifo_empty_evt) |=> rd_data[FIFO_POS]);
  a_r5_mask_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[STALL_MSK_POS]) |=> (rd_data[STALL_MSK_POS] != $past(rd_data[STALL_MSK_POS])));
  a_r6_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == want_irq($past(rd_data))));
  a_r7_holes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE) == 32'd0);
endmodule

bind dma_irq_csr dma_irq_csr_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/dma_irq_csr_test.sv
module dma_irq_csr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] ch_done = '0;
  logic           stall_evt = 1'b0, fifo_empty_evt = 1'b0, bus_err_evt = 1'b0;
  logic [31:0]    rd_data;
  logic           irq;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] mw = '0;
  logic        mirq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_csr #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ch_done(ch_done), .stall_evt(stall_evt), .fifo_empty_evt(fifo_empty_evt),
    .bus_err_evt(bus_err_evt), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req);
    compared++;
    if (rd_data !== mw) begin
      mismatched++;
      $display("FAIL %s rd_data actual=%08h expected=%08h", req, rd_data, mw);
    end
    compared++;
    if (irq !== mirq) begin
      mismatched++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, mirq);
    end
  endtask

  function automatic logic irq_of(input logic [31:0] w);
    logic r = w[15];
    for (int n = 0; n < NCH; n++) if (w[n] && w[16+n]) r = 1'b1;
    if (w[13] && w[29]) r = 1'b1;
    if (w[14] && w[30]) r = 1'b1;
    return r;
  endfunction

  function automatic logic next_sts(input logic cur, input logic ev, input logic clr);
    if (ev) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  // called at a falling edge; applies inputs for one cycle and checks after it
  task automatic step(input logic we, input logic [31:0] wd, input logic [NCH-1:0] ch,
                      input logic st, input logic fe, input logic be, input string req);
    logic [31:0] nw;
    wr_en = we; wr_data = wd; ch_done = ch;
    stall_evt = st; fifo_empty_evt = fe; bus_err_evt = be;
    @(posedge clk);
    mirq = irq_of(mw);
    nw = mw;
    for (int n = 0; n < NCH; n++) begin
      nw[n] = next_sts(mw[n], ch[n], we && wd[n]);
      if (we && wd[16+n]) nw[16+n] = ~mw[16+n];
    end
    nw[13] = next_sts(mw[13], st, we && wd[13]);
    nw[14] = next_sts(mw[14], fe, we && wd[14]);
    nw[15] = next_sts(mw[15], be, we && wd[15]);
    if (we && wd[29]) nw[29] = ~mw[29];
    if (we && wd[30]) nw[30] = ~mw[30];
    mw = nw;
    @(negedge clk);
    check(req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 32'd0, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8");
    end
    rst_n = 1'b1;
    idle("R8");

    // R1: each channel pulse sets its bit and stays
    for (int n = 0; n < NCH; n++) begin
      step(1'b0, 32'd0, NCH'(1) << n, 1'b0, 1'b0, 1'b0, "R1");
      idle("R1");
    end
    // R5/R6: enable all channel masks, interrupt follows one cycle later
    step(1'b1, 32'h03FF_0000, '0, 1'b0, 1'b0, 1'b0, "R5");
    idle("R6");
    // R3: clear half, then the rest
    step(1'b1, 32'h0000_0155, '0, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 32'h0000_02AA, '0, 1'b0, 1'b0, 1'b0, "R3");
    idle("R6");
    // R2: global events
    step(1'b0, 32'd0, '0, 1'b1, 1'b0, 1'b0, "R2");
    step(1'b0, 32'd0, '0, 1'b0, 1'b1, 1'b0, "R2");
    idle("R6");
    step(1'b0, 32'd0, '0, 1'b0, 1'b0, 1'b1, "R2");
    idle("R6");
    step(1'b1, 32'h0000_8000, '0, 1'b0, 1'b0, 1'b0, "R3");
    idle("R6");
    // R5: global masks toggle on and off
    step(1'b1, 32'h6000_0000, '0, 1'b0, 1'b0, 1'b0, "R5");
    idle("R6");
    step(1'b1, 32'h2000_0000, '0, 1'b0, 1'b0, 1'b0, "R5");
    idle("R6");
    // R4: event and clear collide
    step(1'b1, 32'h0000_6008, NCH'(8), 1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 32'h0000_8000, '0, 1'b0, 1'b0, 1'b1, "R4");
    idle("R4");
    // R7: writes to holes only
    step(1'b1, 32'h9C00_1C00, '0, 1'b0, 1'b0, 1'b0, "R7");
    // R7/R3/R5: all-ones write
    step(1'b1, 32'hFFFF_FFFF, '0, 1'b0, 1'b0, 1'b0, "R7");
    idle("R6");
    // R6: random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], $urandom & ((r[1]) ? 32'hFFFF_FFFF : 32'h6000_E3FF),
           NCH'($urandom) & NCH'($urandom), r[2] & r[3], r[4] & r[5], r[6] & r[7] & r[8], "R6");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule